// File: doc/BRIEF.md
# Waited Register Slave for an AHB-Lite Bus

This block is a bus slave that holds a small array of data-width registers behind an AHB-Lite port. Because the bus is pipelined, the control of a transfer is only valid in its address phase, one cycle before the data phase in which the slave acts. The slave therefore copies the qualified select, the write flag, the address, the size, the burst type and the protection bits into a bank of capture registers. It then performs the write or the read from those copies.

The capture bank loads only on a cycle where HREADY is high. A transfer stretched by wait states therefore keeps its own context, even though the master already shows the next address on the bus. The slave adds a fixed number of wait states (parameter `WAIT_CYC`, 0 to 3) to every accepted transfer through HREADYOUT. It returns read data from the captured address, and it answers illegal accesses with a two-cycle ERROR response.

The data phase is run by a state machine with five states. `DP_IDLE`: no transfer is in its data phase. `DP_WAIT`: a legal transfer is being stretched. `DP_XFER`: a legal transfer completes. `DP_ERR1` and `DP_ERR2`: the first and second cycles of an ERROR response. Transitions: from `DP_IDLE`, `DP_XFER` or `DP_ERR2`, with HREADY high, go to `DP_ERR1` for an illegal select, to `DP_WAIT` for a legal select (or straight to `DP_XFER` when `WAIT_CYC` is 0), and to `DP_IDLE` otherwise. With HREADY low these three states hold. `DP_WAIT` stays put while its down-counter is non-zero and then goes to `DP_XFER`. `DP_ERR1` always goes to `DP_ERR2`.

Top module: `ahbl_wait_regslave`

## Requirements
- R1: A transfer is recorded only when HSEL is high and HTRANS is NONSEQ (2'b10) or SEQ (2'b11). IDLE (2'b00) or BUSY (2'b01) with HSEL high, or any HTRANS with HSEL low, leaves HREADYOUT high and HRESP low in the following cycle and writes nothing.
- R2: All captured control loads only on a clock edge with HREADY high and holds while HREADY is low. A write stretched by wait states lands at its own address even though the next address is already on the bus, and the next transfer is captured on the edge where HREADYOUT returns high.
- R3: HWDATA is not captured. It is taken on the edge that completes the write's data phase, and the value on the bus during the address phase has no effect.
- R4: Every legal selected transfer sees HREADYOUT low for exactly `WAIT_CYC` cycles at the start of its data phase, then high for one completing cycle. With no transfer in its data phase, HREADYOUT is high.
- R5: In the completing cycle of a legal read, HRDATA equals the register addressed by the captured address (word index = address bits above the byte offset), including all earlier writes.
- R6: HSIZE codes 0, 1 and 2 mean 1, 2 and 4 bytes. A write updates only the byte lanes of the naturally aligned block of that size that holds the address (lane = address bits [1:0] for bytes, bit [1] picks the halfword).
- R7: An access whose word index is at least `NUM_REGS` or whose HSIZE code exceeds 2 gets ERROR: one cycle with HRESP high and HREADYOUT low, then one cycle with both high. No register is written.
- R8: During and right after reset, HREADYOUT is high, HRESP is low, no transfer is pending and every register reads as zero.
- R9: HRESP is low in every cycle of a legal transfer and while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Active-low asynchronous reset |
| hsel | input | 1 | Slave select from the decoder |
| htrans | input | 2 | Transfer type (IDLE, BUSY, NONSEQ, SEQ) |
| hwrite | input | 1 | High for a write |
| haddr | input | ADDR_W | Byte address |
| hsize | input | 3 | Transfer size code |
| hburst | input | 3 | Burst type, captured with the control |
| hprot | input | 4 | Protection bits, captured with the control |
| hwdata | input | DATA_W | Write data, valid in the data phase |
| hready | input | 1 | Bus-wide ready; high ends the current data phase |
| hreadyout | output | 1 | This slave's ready |
| hresp | output | 1 | Low for OKAY, high for ERROR |
| hrdata | output | DATA_W | Read data from the captured address |

## Verification
Back-to-back writes to neighbouring registers, each stretched by wait states, are read back. These separate a capture gated on HREADY from a free-running one; zero-wait traffic cannot show that difference. Selected IDLE and BUSY cycles, and unselected NONSEQ cycles, carrying write data to a known register show whether the qualification on HTRANS and HSEL holds. Byte and halfword writes into one word show the lane selection. Out-of-range and oversized accesses check the two-cycle ERROR shape and that nothing is written. A seeded random mix of sizes, types and addresses then checks wait counts, responses and read data against a bench-side register model.

// File: rtl/ahbl_slv_pkg.sv
package ahbl_slv_pkg;

    localparam logic [1:0] TR_IDLE   = 2'b00;
    localparam logic [1:0] TR_BUSY   = 2'b01;
    localparam logic [1:0] TR_NONSEQ = 2'b10;
    localparam logic [1:0] TR_SEQ    = 2'b11;

    typedef enum logic [2:0] {
        DP_IDLE,
        DP_WAIT,
        DP_XFER,
        DP_ERR1,
        DP_ERR2
    } dphase_e;

endpackage

// File: rtl/ahbl_ctl_capture.sv
module ahbl_ctl_capture #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hready,
    input  logic              hsel,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic [ADDR_W-1:0] haddr,
    input  logic [2:0]        hsize,
    input  logic [2:0]        hburst,
    input  logic [3:0]        hprot,
    output logic              take_in,
    output logic              sel_q,
    output logic              write_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [2:0]        size_q,
    output logic [2:0]        burst_q,
    output logic [3:0]        prot_q
);
    import ahbl_slv_pkg::*;

    // qualified select: only real transfer types count
    always_comb begin
        take_in = hsel && ((htrans == TR_NONSEQ) || (htrans == TR_SEQ));
    end

    // one shared enable for the whole bank
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= 1'b0;
            write_q <= 1'b0;
            addr_q  <= '0;
            size_q  <= '0;
            burst_q <= '0;
            prot_q  <= '0;
        end else if (hready) begin
            sel_q   <= take_in;
            write_q <= hwrite;
            addr_q  <= haddr;
            size_q  <= hsize;
            burst_q <= hburst;
            prot_q  <= hprot;
        end
    end

    // R1: a selected IDLE or BUSY is never recorded as a transfer
    assert_idle_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (hready && hsel && !htrans[1]) |=> !sel_q)
        else $error("R1: IDLE/BUSY recorded as transfer");

endmodule

// File: rtl/ahbl_dphase_fsm.sv
module ahbl_dphase_fsm #(
    parameter int WAIT_CYC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hready,
    input  logic start_ok,
    input  logic start_err,
    output logic hreadyout,
    output logic hresp,
    output logic commit
);
    import ahbl_slv_pkg::*;

    localparam int CNT_W = 2;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'((WAIT_CYC > 0) ? WAIT_CYC - 1 : 0);

    dphase_e          state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= DP_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            DP_IDLE, DP_XFER, DP_ERR2: begin
                if (hready) begin
                    if (start_err) begin
                        state_nx = DP_ERR1;
                    end else if (start_ok) begin
                        if (WAIT_CYC == 0) begin
                            state_nx = DP_XFER;
                        end else begin
                            state_nx = DP_WAIT;
                            cnt_nx   = CNT_LOAD;
                        end
                    end else begin
                        state_nx = DP_IDLE;
                    end
                end
            end
            DP_WAIT: begin
                if (cnt == '0) begin
                    state_nx = DP_XFER;
                end else begin
                    cnt_nx = cnt - 1'b1;
                end
            end
            DP_ERR1: state_nx = DP_ERR2;
            default: state_nx = DP_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        hreadyout = !((state == DP_WAIT) || (state == DP_ERR1));
        hresp     = (state == DP_ERR1) || (state == DP_ERR2);
        commit    = (state == DP_XFER) && hready;
    end

    // checker: consecutive wait cycles seen so far
    logic [2:0] wait_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_run <= '0;
        end else if (state == DP_WAIT) begin
            wait_run <= (wait_run == 3'd7) ? wait_run : wait_run + 3'd1;
        end else begin
            wait_run <= '0;
        end
    end

    // R4: never more wait cycles than the parameter allows
    assert_wait_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == DP_WAIT) |-> (int'(wait_run) < WAIT_CYC))
        else $error("R4: wait run too long");

endmodule

// File: rtl/ahbl_reg_array.sv
module ahbl_reg_array #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 32,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int LANES   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [LANES-1:0]  wstrb,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);
    logic [NUM_REGS-1:0][DATA_W-1:0] words;

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        for (genvar b = 0; b < LANES; b++) begin : g_lane
            logic [7:0] byte_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    byte_q <= '0;
                end else if (we && (widx == IDX_W'(r)) && wstrb[b]) begin
                    byte_q <= wdata[b*8 +: 8];
                end
            end
            assign words[r][b*8 +: 8] = byte_q;
        end
    end

    always_comb begin
        rdata = (int'(ridx) < NUM_REGS) ? words[ridx] : '0;
    end

    // R6: a write always touches at least one lane
    assert_strb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (wstrb != '0))
        else $error("R6: write with no lane enabled");

endmodule

// File: rtl/ahbl_wait_regslave.sv
module ahbl_wait_regslave #(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 8,
    parameter int WAIT_CYC = 1
) (
    input  logic              hclk,
    input  logic              hresetn,
    input  logic              hsel,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic [ADDR_W-1:0] haddr,
    input  logic [2:0]        hsize,
    input  logic [2:0]        hburst,
    input  logic [3:0]        hprot,
    input  logic [DATA_W-1:0] hwdata,
    input  logic              hready,
    output logic              hreadyout,
    output logic              hresp,
    output logic [DATA_W-1:0] hrdata
);
    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);
    localparam int IDX_W = $clog2(NUM_REGS);

    logic              take_in, in_bad;
    logic              sel_q, write_q;
    logic [ADDR_W-1:0] addr_q;
    logic [2:0]        size_q, burst_q, prot_q_hi;
    logic [3:0]        prot_q;
    logic              commit, wr_en;
    logic [LANES-1:0]  lane_en;
    logic [IDX_W-1:0]  word_idx;

    assign prot_q_hi = prot_q[3:1];

    ahbl_ctl_capture #(.ADDR_W(ADDR_W)) u_cap (
        .clk     (hclk),
        .rst_n   (hresetn),
        .hready  (hready),
        .hsel    (hsel),
        .htrans  (htrans),
        .hwrite  (hwrite),
        .haddr   (haddr),
        .hsize   (hsize),
        .hburst  (hburst),
        .hprot   (hprot),
        .take_in (take_in),
        .sel_q   (sel_q),
        .write_q (write_q),
        .addr_q  (addr_q),
        .size_q  (size_q),
        .burst_q (burst_q),
        .prot_q  (prot_q)
    );

    // legality is decided in the address phase, with the capture
    always_comb begin
        in_bad = ((haddr >> OFF_W) >= ADDR_W'(NUM_REGS)) || (hsize > 3'(OFF_W));
    end

    ahbl_dphase_fsm #(.WAIT_CYC(WAIT_CYC)) u_fsm (
        .clk       (hclk),
        .rst_n     (hresetn),
        .hready    (hready),
        .start_ok  (take_in && !in_bad),
        .start_err (take_in && in_bad),
        .hreadyout (hreadyout),
        .hresp     (hresp),
        .commit    (commit)
    );

    // byte lanes inside the aligned block of the captured size
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            lane_en[l] = ((l >> size_q) == (int'(addr_q[OFF_W-1:0]) >> size_q));
        end
    end

    assign word_idx = addr_q[OFF_W +: IDX_W];
    assign wr_en    = commit && sel_q && write_q;

    ahbl_reg_array #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_regs (
        .clk   (hclk),
        .rst_n (hresetn),
        .we    (wr_en),
        .widx  (word_idx),
        .wstrb (lane_en),
        .wdata (hwdata),
        .ridx  (word_idx),
        .rdata (hrdata)
    );

    // R2: a stretched data phase keeps every captured field
    assert_hold_ctx_R2: assert property (@(posedge hclk) disable iff (!hresetn)
        (!hready && !hreadyout) |=> ($stable(sel_q) && $stable(write_q) && $stable(addr_q)
                                     && $stable(size_q) && $stable(burst_q)
                                     && $stable(prot_q_hi) && $stable(prot_q[0])))
        else $error("R2: captured control changed during wait");

    // R7: first ERROR cycle is a wait
    assert_err_first_R7: assert property (@(posedge hclk) disable iff (!hresetn)
        $rose(hresp) |-> !hreadyout)
        else $error("R7: ERROR started with ready high");

    // R7: second ERROR cycle follows with ready high
    assert_err_second_R7: assert property (@(posedge hclk) disable iff (!hresetn)
        (hresp && !hreadyout) |=> (hresp && hreadyout))
        else $error("R7: ERROR second cycle missing");

    // R7: no write while ERROR is signalled
    assert_err_nowrite_R7: assert property (@(posedge hclk) disable iff (!hresetn)
        hresp |-> !wr_en)
        else $error("R7: write during ERROR");

    // R9: an OKAY data phase always carries a legal captured access
    assert_okay_legal_R9: assert property (@(posedge hclk) disable iff (!hresetn)
        (sel_q && !hresp) |-> (((addr_q >> OFF_W) < ADDR_W'(NUM_REGS)) && (size_q <= 3'(OFF_W))))
        else $error("R9: OKAY on illegal access");

endmodule

// File: tb/ahbl_wait_regslave_bench.sv
module ahbl_wait_regslave_bench;

    localparam int NREG  = 8;
    localparam int WAITS = 2;
    localparam int MAXT  = 256;

    logic        hclk = 1'b0;
    logic        hresetn = 1'b0;
    logic        hsel = 1'b0;
    logic [1:0]  htrans = 2'b00;
    logic        hwrite = 1'b0;
    logic [31:0] haddr = '0;
    logic [2:0]  hsize = 3'd2;
    logic [2:0]  hburst = '0;
    logic [3:0]  hprot = '0;
    logic [31:0] hwdata = '0;
    logic        hready;
    logic        hreadyout;
    logic        hresp;
    logic [31:0] hrdata;

    always #10 hclk = ~hclk;   // 50 MHz

    assign hready = hreadyout;  // single slave on the bus

    ahbl_wait_regslave #(
        .ADDR_W(32), .DATA_W(32), .NUM_REGS(NREG), .WAIT_CYC(WAITS)
    ) u_ahbl_wait_regslave (
        .hclk(hclk), .hresetn(hresetn), .hsel(hsel), .htrans(htrans),
        .hwrite(hwrite), .haddr(haddr), .hsize(hsize), .hburst(hburst),
        .hprot(hprot), .hwdata(hwdata), .hready(hready),
        .hreadyout(hreadyout), .hresp(hresp), .hrdata(hrdata)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic        t_sel   [MAXT];
    logic [1:0]  t_trans [MAXT];
    logic        t_wr    [MAXT];
    logic [31:0] t_addr  [MAXT];
    logic [2:0]  t_size  [MAXT];
    logic [31:0] t_data  [MAXT];
    string       t_tag   [MAXT];
    int          t_cnt = 0;

    logic [31:0] mdl [NREG];

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit is_real(int i);
        return t_sel[i] && t_trans[i][1];
    endfunction

    function automatic bit is_err(int i);
        return ((t_addr[i] >> 2) >= NREG) || (t_size[i] > 3'd2);
    endfunction

    function automatic logic [31:0] apply(logic [31:0] old, logic [31:0] wd,
                                          logic [31:0] a, logic [2:0] s);
        int nb = 1 << s;
        int base = int'(a[1:0]) & ~(nb - 1);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++)
            if (b >= base && b < base + nb) r[b*8 +: 8] = wd[b*8 +: 8];
        return r;
    endfunction

    task automatic add(logic s, logic [1:0] tr, logic w, logic [31:0] a,
                       logic [2:0] sz, logic [31:0] d, string tag);
        t_sel[t_cnt] = s; t_trans[t_cnt] = tr; t_wr[t_cnt] = w;
        t_addr[t_cnt] = a; t_size[t_cnt] = sz; t_data[t_cnt] = d; t_tag[t_cnt] = tag;
        t_cnt++;
    endtask

    task automatic drive_addr(int i);
        hburst = 3'($urandom);
        hprot  = 4'($urandom);
        if (i < t_cnt) begin
            hsel = t_sel[i]; htrans = t_trans[i]; hwrite = t_wr[i];
            haddr = t_addr[i]; hsize = t_size[i];
        end else begin
            hsel = 1'b0; htrans = 2'b00; hwrite = 1'b0;
            haddr = $urandom; hsize = 3'd2;
        end
    endtask

    // pipelined master: address of one transfer overlaps data of the previous
    task automatic run_seq();
        int ai = 0;
        int di = -1;
        int waits = 0;
        bit comp;
        @(negedge hclk);
        drive_addr(0);
        hwdata = $urandom;
        while (ai < t_cnt || di >= 0) begin
            if (di < 0) begin
                check("R1 R4 idle data phase hreadyout", 32'(hreadyout), 32'd1);
                check("R1 R9 idle data phase hresp", 32'(hresp), 32'd0);
            end else if (!hreadyout) begin
                waits++;
                check({t_tag[di], " R7 R9 hresp in wait"}, 32'(hresp), 32'(is_err(di)));
            end else begin
                check({t_tag[di], " R4 R7 wait cycles"}, 32'(waits), is_err(di) ? 32'd1 : 32'(WAITS));
                check({t_tag[di], " R7 R9 hresp at end"}, 32'(hresp), 32'(is_err(di)));
                if (!is_err(di)) begin
                    if (t_wr[di])
                        mdl[t_addr[di] >> 2] = apply(mdl[t_addr[di] >> 2], t_data[di], t_addr[di], t_size[di]);
                    else
                        check({t_tag[di], " R5 hrdata"}, hrdata, mdl[t_addr[di] >> 2]);
                end
            end
            comp = hreadyout;
            @(negedge hclk);
            if (comp) begin
                di = (ai < t_cnt && is_real(ai)) ? ai : -1;
                ai++;
                waits = 0;
                drive_addr(ai);
                hwdata = (di >= 0 && t_wr[di]) ? t_data[di] : $urandom;
            end
        end
        t_cnt = 0;
    endtask

    task automatic print_summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge hclk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R4 watchdog: actual hung expected completion");
            print_summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0A1B));
        for (int i = 0; i < NREG; i++) mdl[i] = '0;

        // R8: reset state
        repeat (3) @(negedge hclk);
        check("R8 hreadyout in reset", 32'(hreadyout), 32'd1);
        check("R8 hresp in reset", 32'(hresp), 32'd0);
        hresetn = 1'b1;
        @(negedge hclk);
        check("R8 hreadyout after reset", 32'(hreadyout), 32'd1);
        check("R8 hresp after reset", 32'(hresp), 32'd0);
        for (int i = 0; i < NREG; i++) add(1'b1, 2'b10, 1'b0, 32'(i * 4), 3'd2, '0, "R8 reset value");
        run_seq();

        // R2 R3: waited back-to-back writes, next address already on the bus
        add(1'b1, 2'b10, 1'b1, 32'h08, 3'd2, 32'h1111_2222, "R2 R3 waited write A");
        add(1'b1, 2'b11, 1'b1, 32'h0C, 3'd2, 32'h3333_4444, "R2 R3 write B after A");
        add(1'b1, 2'b10, 1'b0, 32'h08, 3'd2, '0, "R2 readback A");
        add(1'b1, 2'b11, 1'b0, 32'h0C, 3'd2, '0, "R2 readback B");
        run_seq();

        // R1: unqualified cycles carrying write data to register 4
        add(1'b1, 2'b00, 1'b1, 32'h10, 3'd2, 32'hDEAD_BEEF, "R1 selected IDLE");
        add(1'b1, 2'b01, 1'b1, 32'h10, 3'd2, 32'hDEAD_BEEF, "R1 selected BUSY");
        add(1'b0, 2'b10, 1'b1, 32'h10, 3'd2, 32'hDEAD_BEEF, "R1 unselected NONSEQ");
        add(1'b1, 2'b10, 1'b0, 32'h10, 3'd2, '0, "R1 register 4 untouched");
        run_seq();

        // R6: byte and halfword lanes
        add(1'b1, 2'b10, 1'b1, 32'h14, 3'd2, 32'h0000_0000, "R6 clear word");
        add(1'b1, 2'b10, 1'b1, 32'h15, 3'd0, 32'hAABB_CCDD, "R6 byte lane 1");
        add(1'b1, 2'b10, 1'b1, 32'h16, 3'd1, 32'h1234_5678, "R6 upper halfword");
        add(1'b1, 2'b10, 1'b0, 32'h14, 3'd2, '0, "R6 readback lanes");
        add(1'b1, 2'b10, 1'b1, 32'h18, 3'd2, 32'hFFFF_FFFF, "R6 fill word");
        add(1'b1, 2'b11, 1'b1, 32'h18, 3'd1, 32'h0000_0000, "R6 lower halfword");
        add(1'b1, 2'b11, 1'b1, 32'h1B, 3'd0, 32'h5A00_0000, "R6 byte lane 3");
        add(1'b1, 2'b10, 1'b0, 32'h18, 3'd2, '0, "R6 readback mixed");
        run_seq();

        // R7: illegal accesses
        add(1'b1, 2'b10, 1'b1, 32'h20, 3'd2, 32'hBAD0_0001, "R7 write past array");
        add(1'b1, 2'b10, 1'b1, 32'h04, 3'd3, 32'hBAD0_0002, "R7 oversized write");
        add(1'b1, 2'b10, 1'b0, 32'h40, 3'd2, '0, "R7 read past array");
        add(1'b1, 2'b10, 1'b0, 32'h00, 3'd2, '0, "R7 legal after error");
        for (int i = 0; i < NREG; i++) add(1'b1, 2'b10, 1'b0, 32'(i * 4), 3'd2, '0, "R7 no write on error");
        run_seq();

        // R3 R5: seeded random mix
        for (int i = 0; i < 200; i++) begin
            logic [2:0] sz = ($urandom % 10 == 0) ? 3'd3 : 3'($urandom % 3);
            int nb = (sz > 2) ? 4 : (1 << sz);
            logic [31:0] a = 32'(($urandom % 40) & ~(nb - 1));
            add(($urandom % 10) != 0, 2'($urandom), 1'($urandom), a, sz, $urandom, "R3 R5 random");
            if (t_cnt == 40) run_seq();
        end
        if (t_cnt > 0) run_seq();
        for (int i = 0; i < NREG; i++) add(1'b1, 2'b10, 1'b0, 32'(i * 4), 3'd2, '0, "R5 final readback");
        run_seq();

        finished = 1'b1;
        print_summary();
        $finish;
    end

endmodule